// File: doc/BRIEF.md
# Cascadable LCD Segment Row Loader

This block is the digital core of an 80-column segment driver for a dot-matrix LCD. A display controller sends one row of pixel data, either four bits per shift pulse on a parallel bus or one bit per pulse on a serial line. The block collects the row in a bidirectional shift register. A falling edge on the latch clock then copies the row into an output latch. Each column of the latch is turned into a 2-bit drive-level code. The high-voltage stage downstream turns that code into a bias voltage. The frame-alternation input picks the polarity, and an active-low display-off input blanks the panel.

Several of these blocks can be chained across a wide panel by passing an enable token. A block takes data only while its enable input is low. When its row is full, it pulls its enable output low so that the next block starts loading, and it ignores further pulses. A high level on the latch clock re-arms every block for the next row. The direction input reverses the fill order and swaps which enable pin acts as input and which as output, so a chain can be loaded from either end. All inputs are sampled on `clk`. The shift clock and the latch clock are treated as synchronous levels: each cycle in which `shiftClk` is high counts as one shift pulse.

Top module: `seg_row_loader`

## Requirements
- R1: With `serialMode`=0 each accepted pulse loads all four bits of `dataIn`. With `serialMode`=1 each accepted pulse loads `dataIn[0]` only, and `dataIn[3:1]` have no effect on the loaded row.
- R2: A row is complete after exactly 20 accepted pulses in parallel mode or exactly 80 in serial mode. The token output stays high before the last pulse and goes low in the cycle after it.
- R3: Column c is reported on `levels[2c+1:2c]`. With `dirRev`=0, bit b of the k-th accepted nibble (k counted from 0) lands in column 4k+b, and in serial mode the k-th bit lands in column k. With `dirRev`=1 the target column x becomes 79-x.
- R4: The output latch takes the shift register contents at the first clock on which `latchClk` is low after having been high. Before that edge, `levels` keeps showing the previous row.
- R5: Shift pulses that arrive while the selected enable input is high leave the row and the token unchanged.
- R6: With `dirRev`=0, `enLeftIn` is the enable input and `enRightOut` carries the token, while `enLeftOut` is held high. With `dirRev`=1 the roles swap. Out of reset, both outputs are high.
- R7: While `latchClk` is high, the pulse count and the row-done state are cleared and shift pulses are ignored. Afterwards the token output is high and a new full row is accepted.
- R8: Once a row is complete, further shift pulses are ignored until re-armed.
- R9: With `dispOffN`=0, every column code is 00, whatever the latched data and `frameAlt`.
- R10: With `dispOffN`=1, the column codes are as follows. A latched 1 gives 00 when `frameAlt`=0 and 01 when `frameAlt`=1. A latched 0 gives 10 when `frameAlt`=0 and 11 when `frameAlt`=1. After reset the latch holds all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| serialMode | input | 1 | 0: 4-bit parallel loading, 1: 1-bit serial loading |
| dirRev | input | 1 | 0: left-to-right fill, 1: reversed fill and swapped enable pins |
| shiftClk | input | 1 | Shift pulse; each high cycle is one pulse |
| latchClk | input | 1 | Latch clock; falling edge latches, high level re-arms |
| dataIn | input | 4 | Pixel data; only bit 0 used in serial mode |
| enLeftIn | input | 1 | Left enable pin, input role when dirRev=0 |
| enRightIn | input | 1 | Right enable pin, input role when dirRev=1 |
| enLeftOut | output | 1 | Left enable pin, token output when dirRev=1, else high |
| enRightOut | output | 1 | Right enable pin, token output when dirRev=0, else high |
| frameAlt | input | 1 | Frame-alternation polarity select |
| dispOffN | input | 1 | Active-low display blanking |
| levels | output | 160 | 2-bit drive-level code per column |

## Verification
Assertions check the following on every cycle:
- the pulse count stays within a row;
- the count freezes while the block is disabled or its row is done;
- the latch clock clears the load state;
- the output latch changes only after a detected latch-clock fall;
- blanking zeroes every code.

The bench scenarios are needed for the behaviour that spans a whole row:
- where each nibble or bit lands under both directions and both modes;
- the exact pulse on which the token passes;
- that extra or disabled pulses leave the latched row intact;
- that the level codes follow the polarity input.

// File: rtl/segLoaderPkg.sv
package segLoaderPkg;

  typedef struct packed {
    logic shift;
    logic latch;
  } segStrobes_t;

  typedef enum logic [1:0] {
    LVL_V0    = 2'b00,
    LVL_V5    = 2'b01,
    LVL_MIDHI = 2'b10,
    LVL_MIDLO = 2'b11
  } lvlCode_t;

endpackage

// File: rtl/seg_load_ctrl.sv
module seg_load_ctrl
  import segLoaderPkg::*;
#(
  parameter int NUM_COLS = 80,
  parameter int BUS_W    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        serialMode,
  input  logic        dirRev,
  input  logic        shiftClk,
  input  logic        latchClk,
  input  logic        enLeftIn,
  input  logic        enRightIn,
  output logic        enLeftOut,
  output logic        enRightOut,
  output segStrobes_t strobes
);

  localparam int CNT_W = $clog2(NUM_COLS + 1);
  localparam logic [CNT_W-1:0] LEN_SER = CNT_W'(NUM_COLS);
  localparam logic [CNT_W-1:0] LEN_PAR = CNT_W'(NUM_COLS / BUS_W);

  logic [CNT_W-1:0] loadCnt;
  logic [CNT_W-1:0] rowLen;
  logic             rowDone;
  logic             latchPrev;
  logic             tokenIn;
  logic             tokenOut;
  logic             acceptShift;

  assign rowLen      = serialMode ? LEN_SER : LEN_PAR;
  assign tokenIn     = dirRev ? enRightIn : enLeftIn;
  assign acceptShift = shiftClk & ~tokenIn & ~rowDone & ~latchClk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadCnt   <= '0;
      rowDone   <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      latchPrev <= latchClk;
      if (latchClk) begin
        loadCnt <= '0;
        rowDone <= 1'b0;
      end else if (acceptShift) begin
        loadCnt <= loadCnt + 1'b1;
        if (loadCnt == rowLen - 1'b1) rowDone <= 1'b1;
      end
    end
  end

  assign strobes.shift = acceptShift;
  assign strobes.latch = latchPrev & ~latchClk;

  assign tokenOut   = ~rowDone;
  assign enLeftOut  = dirRev ? tokenOut : 1'b1;
  assign enRightOut = dirRev ? 1'b1 : tokenOut;

  // R2: the count never runs past a serial row
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loadCnt <= LEN_SER);

  // R2: the row completes exactly on the last pulse of the row length
  p_done_at_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rowDone) |-> loadCnt == ($past(serialMode) ? LEN_SER : LEN_PAR));

  // R5: a disabled block holds its count
  p_disabled_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tokenIn && !latchClk) |=> $stable(loadCnt));

  // R8: a completed row accepts nothing more until re-armed
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rowDone && !latchClk) |=> ($stable(loadCnt) && rowDone));

  // R7: latch clock high re-arms the loader
  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    latchClk |=> (loadCnt == '0 && !rowDone));

endmodule

// File: rtl/seg_load_datapath.sv
module seg_load_datapath
  import segLoaderPkg::*;
#(
  parameter int NUM_COLS = 80,
  parameter int BUS_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  segStrobes_t             strobes,
  input  logic                    serialMode,
  input  logic                    dirRev,
  input  logic [BUS_W-1:0]        dataIn,
  input  logic                    frameAlt,
  input  logic                    dispOffN,
  output logic [2*NUM_COLS-1:0]   levels
);

  logic [NUM_COLS-1:0] shiftReg;
  logic [NUM_COLS-1:0] nextReg;
  logic [NUM_COLS-1:0] outLatch;
  logic [BUS_W-1:0]    nibRev;

  for (genvar i = 0; i < BUS_W; i++) begin : g_rev
    assign nibRev[i] = dataIn[BUS_W-1-i];
  end

  always_comb begin
    if (serialMode)
      nextReg = dirRev ? {shiftReg[NUM_COLS-2:0], dataIn[0]}
                       : {dataIn[0], shiftReg[NUM_COLS-1:1]};
    else
      nextReg = dirRev ? {shiftReg[NUM_COLS-BUS_W-1:0], nibRev}
                       : {dataIn, shiftReg[NUM_COLS-1:BUS_W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      outLatch <= '0;
    end else begin
      if (strobes.shift) shiftReg <= nextReg;
      if (strobes.latch) outLatch <= shiftReg;
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    lvlCode_t colLvl;
    always_comb begin
      if (!dispOffN)        colLvl = LVL_V0;
      else if (outLatch[c]) colLvl = frameAlt ? LVL_V5 : LVL_V0;
      else                  colLvl = frameAlt ? LVL_MIDLO : LVL_MIDHI;
    end
    assign levels[2*c +: 2] = colLvl;
  end

  // R4: the output latch only moves after a detected latch-clock fall
  p_latch_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outLatch) |-> $past(strobes.latch));

  // R5: without an accepted pulse the row register holds
  p_shift_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.shift |=> $stable(shiftReg));

  // R9: blanking clears every column code
  p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dispOffN |-> levels == '0);

endmodule

// File: rtl/seg_row_loader.sv
module seg_row_loader
  import segLoaderPkg::*;
#(
  parameter int NUM_COLS = 80,
  parameter int BUS_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  serialMode,
  input  logic                  dirRev,
  input  logic                  shiftClk,
  input  logic                  latchClk,
  input  logic [BUS_W-1:0]      dataIn,
  input  logic                  enLeftIn,
  input  logic                  enRightIn,
  output logic                  enLeftOut,
  output logic                  enRightOut,
  input  logic                  frameAlt,
  input  logic                  dispOffN,
  output logic [2*NUM_COLS-1:0] levels
);

  segStrobes_t strobes;

  seg_load_ctrl #(.NUM_COLS(NUM_COLS), .BUS_W(BUS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .serialMode(serialMode), .dirRev(dirRev),
    .shiftClk(shiftClk), .latchClk(latchClk), .enLeftIn(enLeftIn),
    .enRightIn(enRightIn), .enLeftOut(enLeftOut), .enRightOut(enRightOut),
    .strobes(strobes)
  );

  seg_load_datapath #(.NUM_COLS(NUM_COLS), .BUS_W(BUS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .serialMode(serialMode),
    .dirRev(dirRev), .dataIn(dataIn), .frameAlt(frameAlt),
    .dispOffN(dispOffN), .levels(levels)
  );

  // R6: the pin not carrying the token stays high
  p_idle_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dirRev ? enRightOut : enLeftOut));

endmodule

// File: tb/seg_row_loader_test.sv
module seg_row_loader_test;

  localparam int COLS = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serialMode = 1'b0, dirRev = 1'b0, shiftClk = 1'b0, latchClk = 1'b0;
  logic [3:0] dataIn = '0;
  logic enLeftIn = 1'b0, enRightIn = 1'b1;
  logic enLeftOut, enRightOut;
  logic frameAlt = 1'b0, dispOffN = 1'b1;
  logic [2*COLS-1:0] levels;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  seg_row_loader uut (
    .clk(clk), .rst_n(rst_n), .serialMode(serialMode), .dirRev(dirRev),
    .shiftClk(shiftClk), .latchClk(latchClk), .dataIn(dataIn),
    .enLeftIn(enLeftIn), .enRightIn(enRightIn), .enLeftOut(enLeftOut),
    .enRightOut(enRightOut), .frameAlt(frameAlt), .dispOffN(dispOffN),
    .levels(levels)
  );

  function automatic logic [2*COLS-1:0] expLevels(input logic [COLS-1:0] row,
                                                  input logic m, input logic on);
    logic [2*COLS-1:0] v;
    for (int c = 0; c < COLS; c++) begin
      if (!on)         v[2*c +: 2] = 2'b00;
      else if (row[c]) v[2*c +: 2] = m ? 2'b01 : 2'b00;
      else             v[2*c +: 2] = m ? 2'b11 : 2'b10;
    end
    return v;
  endfunction

  task automatic checkVec(input logic [2*COLS-1:0] act, input logic [2*COLS-1:0] exp,
                          input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkBit(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic tokenPin();
    return dirRev ? enLeftOut : enRightOut;
  endfunction

  task automatic pulse(input logic [3:0] d);
    @(negedge clk);
    dataIn = d; shiftClk = 1'b1;
    @(negedge clk);
    shiftClk = 1'b0;
  endtask

  task automatic latchRow();
    @(negedge clk); latchClk = 1'b1;
    @(negedge clk); latchClk = 1'b0;
    @(negedge clk);
  endtask

  task automatic setDir(input logic d);
    @(negedge clk);
    dirRev = d;
    enLeftIn  = d;
    enRightIn = ~d;
  endtask

  // Loads a full row; the model places bits per R3, checks the token per R2
  task automatic loadRow(input logic ser, output logic [COLS-1:0] row);
    int n = ser ? COLS : COLS / 4;
    logic [3:0] d;
    int col;
    serialMode = ser;
    row = '0;
    for (int k = 0; k < n; k++) begin
      if (k == n - 1) checkBit(tokenPin(), 1'b1, "R2 token high before last pulse");
      d = 4'($urandom);
      pulse(d);
      for (int b = 0; b < (ser ? 1 : 4); b++) begin
        col = ser ? k : 4 * k + b;
        if (dirRev) col = COLS - 1 - col;
        row[col] = d[b];
      end
    end
    checkBit(tokenPin(), 1'b0, "R2 R8 token low after full row");
  endtask

  logic [COLS-1:0] rowA, rowB, lastRow;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkVec(levels, expLevels('0, 1'b0, 1'b1), "R10 reset codes");
    checkBit(enLeftOut & enRightOut, 1'b1, "R6 reset enable outputs");

    // Parallel, left to right
    setDir(1'b0);
    loadRow(1'b0, rowA);
    checkBit(enLeftOut, 1'b1, "R6 idle left pin");
    @(negedge clk); latchClk = 1'b1;
    @(negedge clk);
    checkVec(levels, expLevels('0, 1'b0, 1'b1), "R4 no latch while clock high");
    checkBit(enRightOut, 1'b1, "R7 token re-armed");
    latchClk = 1'b0;
    @(negedge clk);
    checkVec(levels, expLevels(rowA, 1'b0, 1'b1), "R1 R3 R4 parallel dir0 row");
    lastRow = rowA;

    // R8: pulses after the row is full are ignored (token already re-armed, so reload first)
    loadRow(1'b0, rowB);
    for (int i = 0; i < 5; i++) pulse(4'($urandom));
    latchRow();
    checkVec(levels, expLevels(rowB, 1'b0, 1'b1), "R8 extra pulses ignored");
    lastRow = rowB;

    // R5: disabled block ignores pulses
    @(negedge clk); enLeftIn = 1'b1;
    for (int i = 0; i < 20; i++) pulse(4'($urandom));
    checkBit(enRightOut, 1'b1, "R5 token unchanged while disabled");
    latchRow();
    checkVec(levels, expLevels(lastRow, 1'b0, 1'b1), "R5 row unchanged while disabled");

    // R7: pulses during latch-clock high are ignored
    setDir(1'b0);
    @(negedge clk); latchClk = 1'b1; dataIn = 4'hF; shiftClk = 1'b1;
    @(negedge clk); shiftClk = 1'b0; latchClk = 1'b0;
    @(negedge clk);
    checkVec(levels, expLevels(lastRow, 1'b0, 1'b1), "R7 pulse during latch high ignored");

    // Parallel, reversed: right pin is input, left pin carries token
    setDir(1'b1);
    loadRow(1'b0, rowA);
    checkBit(enRightOut, 1'b1, "R6 idle right pin when reversed");
    latchRow();
    checkVec(levels, expLevels(rowA, 1'b0, 1'b1), "R3 parallel dir1 row");

    // Serial, both directions, junk on upper bits
    setDir(1'b0);
    loadRow(1'b1, rowA);
    latchRow();
    checkVec(levels, expLevels(rowA, 1'b0, 1'b1), "R1 R3 serial dir0 row");
    setDir(1'b1);
    loadRow(1'b1, rowB);
    latchRow();
    checkVec(levels, expLevels(rowB, 1'b0, 1'b1), "R1 R3 serial dir1 row");

    // Polarity and blanking
    @(negedge clk); frameAlt = 1'b1;
    @(negedge clk);
    checkVec(levels, expLevels(rowB, 1'b1, 1'b1), "R10 codes with frameAlt high");
    dispOffN = 1'b0;
    @(negedge clk);
    checkVec(levels, '0, "R9 blanking with frameAlt high");
    frameAlt = 1'b0;
    @(negedge clk);
    checkVec(levels, '0, "R9 blanking with frameAlt low");
    dispOffN = 1'b1;

    // Random rows
    for (int it = 0; it < 8; it++) begin
      logic ser, m;
      ser = 1'($urandom);
      m   = 1'($urandom);
      setDir(1'($urandom));
      frameAlt = m;
      loadRow(ser, rowA);
      latchRow();
      checkVec(levels, expLevels(rowA, m, 1'b1), "R3 R10 random row");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule